// File: doc/BRIEF.md
# Power Sequencer with Serial Command Receiver

This block sequences the reset of a host system from a power-good input and also serves as the receiving end of a byte-wide serial command link driven by that host. While the power-good line is low, the system reset is held low. When power-good rises, the reset is released, and the block then signals readiness by pulling its ready line low. When power-good falls during normal operation, the block raises a low-active interrupt. It keeps the system out of reset until the host acknowledges by pulling its stop line low, or until a timeout runs out. Either event then drives the system reset low.

The host clocks each byte in with eight serial clock pulses, most significant bit first. The data line is sampled on the rising edges. After the eighth edge the ready line goes high for a programmable busy time. The received byte is offered on a valid/ready stream output. The valid signal stays high, with the data frozen, until the consumer takes the byte. The ready line returns low only after the busy time has elapsed and the byte has been taken, so a slow consumer pushes back on the host through the ready line. All asynchronous inputs pass through a synchronizer before they are used.

Top module: `pwr_seq_link`

## Requirements
- R1: After the block reset, sys_rst_n_o is 0, irq_n_o is 1, rdy_n_o is 1 and rx_valid_o is 0.
- R2: sys_rst_n_o stays 0 while pwr_ok_i is 0 and goes to 1 within a few cycles after pwr_ok_i becomes 1.
- R3: rdy_n_o is 0 only while sys_rst_n_o is 1, and it goes to 0 once the reset has been released and no byte is pending.
- R4: While rdy_n_o is 0, eight rising edges of sclk_i shift in one byte. The bit sampled on the first edge lands in bit 7 of rx_data_o and the last in bit 0, and rx_valid_o is raised.
- R5: When rx_valid_o rises, rdy_n_o is 1. It stays 1 for max(BUSY_CYC, A) cycles counted from that rise, where A is the number of cycles until the byte is accepted.
- R6: While rx_valid_o is 1 and rx_ready_i is 0, rx_valid_o stays 1 and rx_data_o stays unchanged. A byte is accepted in a cycle where both are 1.
- R7: Rising edges of sclk_i while rdy_n_o is 1 are ignored; the next byte after them is received intact.
- R8: When pwr_ok_i falls while the reset is released, irq_n_o goes to 0 and sys_rst_n_o stays 1.
- R9: While irq_n_o is 0, host_stop_n_i going to 0 drives sys_rst_n_o to 0 and returns irq_n_o to 1.
- R10: host_stop_n_i going to 0 while irq_n_o is 1 has no effect on sys_rst_n_o.
- R11: If host_stop_n_i stays 1 for HALT_TMO cycles after the interrupt, sys_rst_n_o is forced to 0 anyway.
- R12: A return of pwr_ok_i while the interrupt is pending does not cancel the shutdown. After the reset has been asserted, it is released again once pwr_ok_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| pwr_ok_i | input | 1 | Power-good indication, asynchronous |
| host_stop_n_i | input | 1 | Host stop acknowledge, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdata_i | input | 1 | Serial data from the host, asynchronous |
| rx_ready_i | input | 1 | Consumer accepts the offered byte |
| sys_rst_n_o | output | 1 | System reset, 1 = released |
| irq_n_o | output | 1 | Power-loss interrupt, active low |
| rdy_n_o | output | 1 | Link ready, 0 = next byte may be sent |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte is valid |

## Verification
The receive path is swept over all 256 byte values. Each value is sent with a different consumer hold time, so one sweep catches a wrong bit order or a dropped bit. It also catches a busy time that does not take the larger of the fixed delay and the acceptance delay, and data that moves while it waits. Extra clock pulses are sent while a byte is held and while power is off, which shows that the bit counter only advances while the ready line is low. The power sequence is run through four cases: a stop pulse with no interrupt pending, a stop acknowledge, a power-good bounce during the interrupt, and a silent host. These separate the acknowledge path, the timeout path and the no-cancel rule.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_ALERT = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int HALT_TMO = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic stop_n,
  output logic sys_rst_n,
  output logic irq_n,
  output logic link_en
);
  localparam int TW = $clog2(HALT_TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(HALT_TMO - 1);

  pwr_state_e st_q, st_d;
  logic [TW-1:0] tmo_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_OFF:   if (pwr_ok) st_d = PS_ON;
      PS_ON:    if (!pwr_ok) st_d = PS_ALERT;
      PS_ALERT: if (!stop_n || tmo_q == TMO_LAST) st_d = PS_OFF;
      default:  st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      tmo_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != PS_ALERT) tmo_q <= '0;
      else if (tmo_q != TMO_LAST) tmo_q <= tmo_q + 1'b1;
    end
  end

  assign sys_rst_n = (st_q != PS_OFF);
  assign irq_n     = (st_q != PS_ALERT);
  assign link_en   = (st_q != PS_OFF);
endmodule

// File: rtl/pwrseq_rx.sv
module pwrseq_rx #(
  parameter int DW = 8,
  parameter int BUSY_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sclk_s,
  input  logic          sdat_s,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          rdy_n
);
  localparam int CW = $clog2(DW);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(DW - 1);
  localparam logic [BW-1:0] BUSY_LD  = BW'(BUSY_CYC);

  logic          sclk_prev;
  logic [CW-1:0] bit_q;
  logic [DW-1:0] shf_q;
  logic [BW-1:0] busy_q;
  logic          open_w;
  logic          rise_w;

  assign open_w = en && (busy_q == '0) && !out_valid;
  assign rise_w = sclk_s && !sclk_prev;
  assign rdy_n  = !open_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      shf_q     <= '0;
      busy_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (!en) begin
      bit_q     <= '0;
      busy_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (open_w && rise_w) begin
        shf_q <= {shf_q[DW-2:0], sdat_s};
        if (bit_q == BIT_LAST) begin
          bit_q     <= '0;
          out_data  <= {shf_q[DW-2:0], sdat_s};
          out_valid <= 1'b1;
          busy_q    <= BUSY_LD;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_seq_link.sv
module pwr_seq_link #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYC = 16,
  parameter int HALT_TMO = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_i,
  input  logic          host_stop_n_i,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          rx_ready_i,
  output logic          sys_rst_n_o,
  output logic          irq_n_o,
  output logic          rdy_n_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o
);
  logic [3:0] raw_w, syn_w;
  logic       link_en;

  assign raw_w = {pwr_ok_i, host_stop_n_i, sclk_i, sdata_i};

  pwrseq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
  );

  pwrseq_ctrl #(.HALT_TMO(HALT_TMO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_ok(syn_w[3]), .stop_n(syn_w[2]),
    .sys_rst_n(sys_rst_n_o), .irq_n(irq_n_o), .link_en(link_en)
  );

  pwrseq_rx #(.DW(DW), .BUSY_CYC(BUSY_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(link_en), .sclk_s(syn_w[1]), .sdat_s(syn_w[0]),
    .out_ready(rx_ready_i), .out_data(rx_data_o), .out_valid(rx_valid_o),
    .rdy_n(rdy_n_o)
  );
endmodule

// File: rtl/pwr_seq_link_chk.sv
module pwr_seq_link_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_rst_n_o,
  input logic          irq_n_o,
  input logic          rdy_n_o,
  input logic          rx_ready_i,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_valid_o
);
  // R3
  rdy_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n_o |-> rdy_n_o);

  // R8
  irq_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> sys_rst_n_o);

  // R9
  irq_ends_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> !sys_rst_n_o);

  // R5
  busy_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> rdy_n_o);

  // R6
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && sys_rst_n_o) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind pwr_seq_link pwr_seq_link_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst_n_o(sys_rst_n_o), .irq_n_o(irq_n_o),
  .rdy_n_o(rdy_n_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/tb_pwr_seq_link.sv
module tb_pwr_seq_link;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 6;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, stop_n = 1'b1, sclk = 1'b0, sdat = 1'b0, rx_ready = 1'b0;
  logic sys_rst_n, irq_n, rdy_n, rx_valid;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_link #(.DW(8), .SYNC_STAGES(2), .BUSY_CYC(BUSY), .HALT_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .host_stop_n_i(stop_n),
    .sclk_i(sclk), .sdata_i(sdat), .rx_ready_i(rx_ready), .sys_rst_n_o(sys_rst_n),
    .irq_n_o(irq_n), .rdy_n_o(rdy_n), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdat = b; cyc(3);
    sclk = 1'b1; cyc(3);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) pulse_bit(v[i]);
  endtask

  // wait for valid; returns 1 if seen
  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (rx_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // R4 R5 R6: receive one byte with consumer holding for k cycles
  task automatic rx_one(input logic [7:0] v, input int k);
    bit seen;
    int cnt, expc;
    logic [7:0] first;
    send_byte(v);
    wait_valid(seen);
    chk("R4 valid", int'(seen), 1);
    chk("R4 data", int'(rx_data), int'(v));
    chk("R5 busy at valid", int'(rdy_n), 1);
    first = rx_data;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == k) rx_ready = 1'b1;
      if (!rdy_n) break;
      if (i < k && rx_data != first) chk("R6 stable", int'(rx_data), int'(first));
      if (i < k) chk("R6 held", int'(rx_valid), 1);
      cnt++;
      @(negedge clk);
    end
    rx_ready = 1'b0;
    expc = (BUSY > k + 1) ? BUSY : k + 1;
    chk("R5 busy length", cnt, expc);
  endtask

  initial begin
    cyc(200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk("R1 sys_rst_n", int'(sys_rst_n), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 rdy_n", int'(rdy_n), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);

    // R2 R7: pulses with power off are ignored
    send_byte(8'hFF);
    chk("R2 held in reset", int'(sys_rst_n), 0);
    chk("R3 not ready in reset", int'(rdy_n), 1);
    chk("R7 no byte while off", int'(rx_valid), 0);
    pwr_ok = 1'b1; cyc(6);
    chk("R2 released", int'(sys_rst_n), 1);
    chk("R3 ready after release", int'(rdy_n), 0);

    // R4 R5 R6 exhaustive byte sweep
    for (int v = 0; v < 256; v++) rx_one(8'(v), v % 9);

    // R7: pulses while a byte is held
    send_byte(8'hA5);
    wait_valid(seen);
    chk("R7 first byte", int'(rx_data), 8'hA5);
    for (int i = 0; i < 5; i++) pulse_bit(1'b1);
    chk("R7 still held", int'(rx_data), 8'hA5);
    rx_ready = 1'b1; cyc(2); rx_ready = 1'b0;
    cyc(BUSY);
    chk("R7 ready again", int'(rdy_n), 0);
    rx_one(8'h3C, 0);

    // R10: stop without interrupt
    stop_n = 1'b0; cyc(10);
    chk("R10 sys stays", int'(sys_rst_n), 1);
    chk("R10 irq idle", int'(irq_n), 1);
    stop_n = 1'b1; cyc(4);

    // R8 R12 R9
    pwr_ok = 1'b0; cyc(6);
    chk("R8 irq", int'(irq_n), 0);
    chk("R8 sys kept", int'(sys_rst_n), 1);
    pwr_ok = 1'b1; cyc(10);
    chk("R12 no cancel", int'(irq_n), 0);
    stop_n = 1'b0; pwr_ok = 1'b0; cyc(6);
    chk("R9 reset", int'(sys_rst_n), 0);
    chk("R9 irq cleared", int'(irq_n), 1);
    chk("R3 rdy in reset", int'(rdy_n), 1);
    stop_n = 1'b1; cyc(8);
    chk("R12 stays off", int'(sys_rst_n), 0);
    pwr_ok = 1'b1; cyc(6);
    chk("R12 re-release", int'(sys_rst_n), 1);

    // R11 timeout
    pwr_ok = 1'b0; cyc(6);
    chk("R11 irq", int'(irq_n), 0);
    cyc(TMO - 12);
    chk("R11 before timeout", int'(sys_rst_n), 1);
    cyc(16);
    chk("R11 forced reset", int'(sys_rst_n), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule